// File: doc/BRIEF.md
# UART Receive Idle-Line Detector

This block watches a UART receive line, one sample per bit time, and raises an idle flag once the line has been continuously high for a full character time after some receive activity. The receiver that sits beside it supplies a bit-time tick, the line level, a strobe at each start bit and each stop bit, and a strobe when a character lands in the receive data register. The detector turns these into one status bit.

Two counting policies are selectable. In the early policy, high bit times count from the start bit onward, so high data bits at the end of a character and its stop bit already count toward idle. In the late policy, counting begins only once the stop bit has been accepted. The character time is the data width plus two framing bits, plus one more bit when the long-frame input is high. The flag is one-shot: it rises once per idle period and cannot rise again until a fresh character has been received. Software clears it with a status read that sees the flag set, followed by a data read.

The controller has four states. DISARMED (after reset or a clear) goes to ARMED on a received-character strobe. ARMED goes to FLAGGED when the quiet count reaches one character time. FLAGGED goes to RD_PEND on a status read. RD_PEND goes to DISARMED on a data read. Every other input leaves the state as it is.

Top module: `uart_idle_detect`

## Requirements
- R1: With the default 8 data bits, one character time is 10 bit times when `long_frame` is 0 and 11 when it is 1. The flag rises when the quiet count reaches that value and not one bit time before.
- R2: With `after_stop` = 0, a `start_evt` restarts the count at zero, and every later high bit-time sample counts, including trailing high data bits and the stop bit.
- R3: With `after_stop` = 1, samples between `start_evt` and `stop_evt` do not count. The count restarts at zero on `stop_evt`, so a full character time of high samples is needed after the stop bit.
- R4: When `status_rd` is pulsed while `idle_flag` is 1 and is later followed by a `data_rd` pulse, `idle_flag` is 0 from the clock edge after the `data_rd` edge.
- R5: A `data_rd` with no status read seen while the flag was set leaves `idle_flag` at 1. A status read taken before the flag rose does not count.
- R6: After a clear, `idle_flag` stays 0 however long the line is high, until a `rx_char_evt` arrives. A `rx_char_evt` that arrives while the flag is set or a clear is pending does not re-arm the detector.
- R7: A bit-time sample with the line low resets the quiet count to zero.
- R8: After reset, `idle_flag` is 0 and the detector is disarmed, so a high line before the first received character never sets the flag.
- R9: Once set, `idle_flag` stays at 1 through any number of further idle bit times until the clear handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse, one per bit time; the line is sampled in this cycle |
| rx_line | input | 1 | Receive line level |
| start_evt | input | 1 | Pulse from the receiver when a start bit is accepted |
| stop_evt | input | 1 | Pulse from the receiver when a stop bit is accepted |
| rx_char_evt | input | 1 | Pulse when a character is moved into the receive data register |
| long_frame | input | 1 | 0: character is DATA_BITS+2 bit times; 1: DATA_BITS+3 |
| after_stop | input | 1 | 0: count from start bit; 1: count from stop bit |
| status_rd | input | 1 | Pulse on a status register read |
| data_rd | input | 1 | Pulse on a data register read |
| idle_flag | output | 1 | Idle-line flag |

## Verification
On every cycle, the assertions check that the flag falls only right after a data read, and that a data read with no qualifying status read leaves it set. They also check that the flag rises only after a full quiet count, that it holds while no data read occurs, that the count never passes one character time, and that a low sample empties the count. Only the bench scenarios can show the sequence properties. These are the exact bit-time on which the flag rises in each counting policy and frame length, the reset-to-zero on a low bit in mid-count, the refusal to re-set after a clear without a new character, and the power-up line not counting.

// File: rtl/uart_idle_pkg.sv
package uart_idle_pkg;

    // Controller states of the idle flag
    typedef enum logic [1:0] {
        IDL_DISARMED = 2'd0,  // waiting for a received character
        IDL_ARMED    = 2'd1,  // counting toward one character time
        IDL_FLAGGED  = 2'd2,  // flag set, no status read seen yet
        IDL_RD_PEND  = 2'd3   // flag set, status read seen, awaiting data read
    } idl_state_e;

    // Bit times in one character: start + data + stop (+ one extra when long)
    function automatic int unsigned char_bit_times(input int unsigned data_bits,
                                                   input logic long_frame);
        return data_bits + 2 + (long_frame ? 1 : 0);
    endfunction

endpackage

// File: rtl/idle_high_counter.sv
module idle_high_counter #(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned CNT_W     = $clog2(DATA_BITS + 4)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic after_stop,
    input  logic long_frame,
    output logic line_quiet
);
    import uart_idle_pkg::*;

    localparam int unsigned SHORT_LEN = DATA_BITS + 2;
    localparam int unsigned LONG_LEN  = DATA_BITS + 3;

    logic [CNT_W-1:0] high_cnt;
    logic [CNT_W-1:0] target;
    logic             counting;   // counting window open

    assign target = CNT_W'(char_bit_times(DATA_BITS, long_frame));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= '0;
            counting <= 1'b0;
        end else if (start_evt) begin
            // New character: early policy opens the window, late policy closes it
            high_cnt <= '0;
            counting <= !after_stop;
        end else if (stop_evt && after_stop) begin
            high_cnt <= '0;
            counting <= 1'b1;
        end else if (bit_tick && counting) begin
            if (!rx_line) begin
                high_cnt <= '0;
            end else if (high_cnt < target) begin
                high_cnt <= high_cnt + 1'b1;
            end
        end
    end

    assign line_quiet = (high_cnt >= target);

    // Assertions
    a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        high_cnt <= CNT_W'(LONG_LEN));

    a_r7_low_tick_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && counting && !rx_line && !start_evt && !stop_evt)
        |=> (high_cnt == '0) && !line_quiet);

    a_r1_short_frame_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (!long_frame && line_quiet) |-> (high_cnt >= CNT_W'(SHORT_LEN)));

endmodule

// File: rtl/idle_flag_fsm.sv
module idle_flag_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic line_quiet,
    input  logic rx_char_evt,
    input  logic status_rd,
    input  logic data_rd,
    output logic idle_flag
);
    import uart_idle_pkg::*;

    idl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IDL_DISARMED;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDL_DISARMED: if (rx_char_evt) state_d = IDL_ARMED;
            IDL_ARMED:    if (line_quiet)  state_d = IDL_FLAGGED;
            IDL_FLAGGED:  if (status_rd)   state_d = IDL_RD_PEND;
            IDL_RD_PEND:  if (data_rd)     state_d = IDL_DISARMED;
            default:                       state_d = IDL_DISARMED;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            IDL_FLAGGED, IDL_RD_PEND: idle_flag = 1'b1;
            default:                  idle_flag = 1'b0;
        endcase
    end

    // Assertions
    a_r4_fall_after_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_flag) |-> $past(data_rd));

    a_r5_data_alone_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IDL_FLAGGED && data_rd) |=> idle_flag);

    a_r1_rise_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(line_quiet));

    a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !data_rd) |=> idle_flag);

endmodule

// File: rtl/uart_idle_detect.sv
module uart_idle_detect #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_line,
    input  logic start_evt,
    input  logic stop_evt,
    input  logic rx_char_evt,
    input  logic long_frame,
    input  logic after_stop,
    input  logic status_rd,
    input  logic data_rd,
    output logic idle_flag
);
    localparam int unsigned CNT_W = $clog2(DATA_BITS + 4);

    logic line_quiet;

    idle_high_counter #(
        .DATA_BITS (DATA_BITS),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .rx_line    (rx_line),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .after_stop (after_stop),
        .long_frame (long_frame),
        .line_quiet (line_quiet)
    );

    idle_flag_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_quiet  (line_quiet),
        .rx_char_evt (rx_char_evt),
        .status_rd   (status_rd),
        .data_rd     (data_rd),
        .idle_flag   (idle_flag)
    );

    // R8: a flag may only appear after the first edge out of reset
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !idle_flag);

endmodule

// File: tb/tb_uart_idle_detect.sv
`timescale 1ns/1ps
module tb_uart_idle_detect;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0, rx_line = 1'b1, start_evt = 1'b0, stop_evt = 1'b0;
    logic rx_char_evt = 1'b0, long_frame = 1'b0, after_stop = 1'b0;
    logic status_rd = 1'b0, data_rd = 1'b0;
    logic idle_flag;

    always #2.5 clk = ~clk;   // 200 MHz

    uart_idle_detect dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_line(rx_line),
        .start_evt(start_evt), .stop_evt(stop_evt), .rx_char_evt(rx_char_evt),
        .long_frame(long_frame), .after_stop(after_stop),
        .status_rd(status_rd), .data_rd(data_rd), .idle_flag(idle_flag)
    );

    typedef struct {
        logic  exp;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Monitor: pops expectations and compares against the output
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                tests++;
                if (idle_flag !== it.exp) begin
                    fails++;
                    $display("FAIL %s: idle_flag=%b expected=%b", it.tag, idle_flag, it.exp);
                end
            end
        end
    end

    // Driver helpers (each leaves two idle cycles so the flag has settled)
    task automatic expect_flag(input logic e, input string tag);
        sb_q.push_back('{exp: e, tag: tag});
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        bit_tick = 0; start_evt = 0; stop_evt = 0; rx_char_evt = 0;
        status_rd = 0; data_rd = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic tick(input logic lvl);
        @(negedge clk); rx_line = lvl; bit_tick = 1'b1;
        settle();
        rx_line = 1'b1;
    endtask

    task automatic ticks_high(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic pulse_start();  @(negedge clk); start_evt = 1'b1;   settle(); endtask
    task automatic pulse_stop();   @(negedge clk); stop_evt = 1'b1;    settle(); endtask
    task automatic pulse_char();   @(negedge clk); rx_char_evt = 1'b1; settle(); endtask
    task automatic pulse_status(); @(negedge clk); status_rd = 1'b1;   settle(); endtask
    task automatic pulse_data();   @(negedge clk); data_rd = 1'b1;     settle(); endtask

    // A full 8-bit character, LSB first, ending with the received strobe
    task automatic send_char(input logic [7:0] d);
        pulse_start();
        tick(1'b0);
        for (int b = 0; b < 8; b++) tick(d[b]);
        tick(1'b1);
        pulse_stop();
        pulse_char();
    endtask

    task automatic clear_flag();
        pulse_status();
        pulse_data();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        expect_flag(1'b0, "R8 reset value");
        rst_n = 1'b1;
        @(negedge clk);

        // R8: power-up idle line does not set the flag
        ticks_high(25);
        expect_flag(1'b0, "R8 idle before first character");

        // R2 + R1: early policy, short frame, all-ones data -> 9 highs after start
        after_stop = 0; long_frame = 0;
        send_char(8'hFF);
        expect_flag(1'b0, "R1 nine bit times not enough");
        tick(1'b1);
        expect_flag(1'b1, "R2 trailing ones and stop count");

        // R9: stays set through long idle
        ticks_high(30);
        expect_flag(1'b1, "R9 flag holds while idle");

        // R5: data read alone does not clear
        pulse_data();
        expect_flag(1'b1, "R5 data read without status read");

        // R4: proper handshake clears
        clear_flag();
        expect_flag(1'b0, "R4 status then data read clears");

        // R6: no re-set without a new character
        ticks_high(30);
        expect_flag(1'b0, "R6 no re-set after clear");

        // R3: late policy, short frame
        after_stop = 1; long_frame = 0;
        send_char(8'hFF);
        ticks_high(9);
        expect_flag(1'b0, "R3 stop bit and trailing ones do not count");
        tick(1'b1);
        expect_flag(1'b1, "R3 ten bit times after stop");

        // R6: character strobe while set does not re-arm after the clear
        pulse_char();
        clear_flag();
        ticks_high(20);
        expect_flag(1'b0, "R6 strobe during set ignored");

        // R1: long frame, early policy, zero data -> only the stop bit counts
        after_stop = 0; long_frame = 1;
        send_char(8'h00);
        ticks_high(9);
        expect_flag(1'b0, "R1 ten bit times short of long frame");
        tick(1'b1);
        expect_flag(1'b1, "R1 eleven bit times in long frame");
        clear_flag();
        expect_flag(1'b0, "R4 clear in long frame");

        // R7: low bit restarts the count (late policy, short frame)
        after_stop = 1; long_frame = 0;
        send_char(8'hA5);
        ticks_high(7);
        tick(1'b0);
        ticks_high(9);
        expect_flag(1'b0, "R7 low bit resets count");
        tick(1'b1);
        expect_flag(1'b1, "R7 full run after low bit");

        // R5: status read taken before the flag rose does not qualify
        clear_flag();
        after_stop = 0;
        send_char(8'hFF);
        pulse_status();
        tick(1'b1);
        expect_flag(1'b1, "R5 flag set after early status read");
        pulse_data();
        expect_flag(1'b1, "R5 early status read does not qualify");
        clear_flag();
        expect_flag(1'b0, "R4 final clear");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule